// File: doc/BRIEF.md
# Host-Card Shared Window Decoder with Interrupt Doorbells

This block sits between a simple synchronous model of a legacy host expansion bus and an on-card processor. It holds a base register that places an 8 KB shared-memory window inside the host's 1 MB memory space. Whenever a host memory cycle addresses that window, the block raises a select. The top address bit of the base is fixed at 1 and its lowest bit is fixed at 0. The window can therefore only sit on 8 KB boundaries from 0x80000 up to 0xFE000.

The block also carries a set of doorbell flags that pass interrupts in both directions. The host rings the card's interrupt lines with write-one-to-set, and the card clears them with write-one-to-clear. The card rings the host's interrupt line, and the host acknowledges it with write-one-to-clear. Each flag drives its interrupt output as a level, and the host can read every flag back to see whether that interrupt is still pending.

Top module: `isa_window_doorbell`

## Requirements
- R1: A synchronous reset sets the base readback to 0x80 and clears every doorbell flag and interrupt output to 0.
- R2: Base readback bit 7 (address line 19) always reads 1, and bit 0 (address line 12) always reads 0, whatever value is written.
- R3: A host base write loads write-data bits 6..1 into readback bits 6..1 on the next clock edge. A readback value of 0xNN places the window base at host address 0xNN000.
- R4: While the memory strobe is high, the window select equals the comparison of host address bits 19..13 with readback bits 7..1. Address bit 12 is ignored, so the window spans 8 KB.
- R5: The window select is low whenever the memory strobe is low.
- R6: A host doorbell write with data bit k = 1 (k = 0 or 1) sets card flag k on the next edge. A data bit of 0 leaves that flag unchanged.
- R7: A card clear input bit k of 1 clears card flag k on the next edge.
- R8: When a set and a clear reach the same flag in one cycle, the flag ends up set. This applies to card flags and to the host flag.
- R9: The card's raise-host input sets the host flag on the next edge.
- R10: A host doorbell write with data bit 2 = 1 clears the host flag. A data bit 2 of 0 leaves it unchanged.
- R11: Doorbell readback holds the card flags in bits 1..0 and the host flag in bit 2. The interrupt outputs equal those flags as levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 20 | Host memory address |
| mem_strobe | input | 1 | Host memory read or write cycle in progress |
| win_sel | output | 1 | Shared window selected |
| base_wr | input | 1 | Host write strobe for the base register |
| bell_wr | input | 1 | Host write strobe for the doorbell register |
| host_wdata | input | 8 | Host write data |
| base_rdata | output | 8 | Base register readback |
| bell_rdata | output | 3 | Doorbell readback: host flag, card flag 1, card flag 0 |
| card_raise_host | input | 1 | Card request to set the host flag |
| card_clr | input | 2 | Card write-one-to-clear of its own flags |
| host_irq | output | 1 | Interrupt level to the host |
| card_irq | output | 2 | Interrupt levels to the card processor |

## Verification
The bench writes all-ones and all-zeros to the base register. A design that stored the fixed bits would then read back 0xFF or 0x00 and move the window below 0x80000. It probes addresses on both sides of the window edges, including the upper 4 KB half where address bit 12 is 1. A decoder that compared bit 12 would drop half the window. It drives set and clear onto the same flag in one cycle, and writes zeros to the doorbell register. A design with the wrong priority would lose a ring, and one that treated the zeros as active would clear or raise flags by accident. A long random phase then compares every output against a behavioural model on each cycle.

// File: rtl/isa_window_doorbell.sv
module isa_window_doorbell #(
  parameter int ADDR_W    = 20,
  parameter int REG_LSB   = 12,
  parameter int CARD_IRQS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    host_addr,
  input  logic                 mem_strobe,
  output logic                 win_sel,
  input  logic                 base_wr,
  input  logic                 bell_wr,
  input  logic [7:0]           host_wdata,
  output logic [ADDR_W-REG_LSB-1:0] base_rdata,
  output logic [CARD_IRQS:0]   bell_rdata,
  input  logic                 card_raise_host,
  input  logic [CARD_IRQS-1:0] card_clr,
  output logic                 host_irq,
  output logic [CARD_IRQS-1:0] card_irq
);
  localparam int REG_W = ADDR_W - REG_LSB;
  localparam int RW_W  = REG_W - 2;

  logic [RW_W-1:0]      base_q;
  logic [CARD_IRQS-1:0] card_q;
  logic                 host_q;

  always_ff @(posedge clk) begin
    if (rst)          base_q <= '0;
    else if (base_wr) base_q <= host_wdata[RW_W:1];
  end

  assign base_rdata = {1'b1, base_q, 1'b0};
  assign win_sel    = mem_strobe && (host_addr[ADDR_W-1:REG_LSB+1] == base_rdata[REG_W-1:1]);

  for (genvar k = 0; k < CARD_IRQS; k++) begin : g_card
    logic set_k;
    assign set_k = bell_wr && host_wdata[k];
    always_ff @(posedge clk) begin
      if (rst)              card_q[k] <= 1'b0;
      else if (set_k)       card_q[k] <= 1'b1;
      else if (card_clr[k]) card_q[k] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                 host_q <= 1'b0;
    else if (card_raise_host)                host_q <= 1'b1;
    else if (bell_wr && host_wdata[CARD_IRQS]) host_q <= 1'b0;
  end

  assign bell_rdata = {host_q, card_q};
  assign host_irq   = host_q;
  assign card_irq   = card_q;
endmodule

// File: rtl/isa_window_doorbell_chk.sv
module isa_window_doorbell_chk #(
  parameter int ADDR_W    = 20,
  parameter int REG_LSB   = 12,
  parameter int CARD_IRQS = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic [ADDR_W-1:0]    host_addr,
  input logic                 mem_strobe,
  input logic                 win_sel,
  input logic                 base_wr,
  input logic                 bell_wr,
  input logic [7:0]           host_wdata,
  input logic [ADDR_W-REG_LSB-1:0] base_rdata,
  input logic [CARD_IRQS:0]   bell_rdata,
  input logic                 card_raise_host,
  input logic [CARD_IRQS-1:0] card_clr,
  input logic                 host_irq,
  input logic [CARD_IRQS-1:0] card_irq
);
  localparam int REG_W = ADDR_W - REG_LSB;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (base_rdata == {1'b1, {(REG_W-1){1'b0}}}) && (bell_rdata == '0));

  // R3
  base_load_chk: assert property (@(posedge clk) disable iff (rst)
    base_wr |=> base_rdata[REG_W-2:1] == $past(host_wdata[REG_W-2:1]));

  // R5
  sel_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    win_sel |-> mem_strobe);

  // R6
  card0_set_chk: assert property (@(posedge clk) disable iff (rst)
    (bell_wr && host_wdata[0]) |=> card_irq[0]);

  // R7
  card0_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (card_clr[0] && !(bell_wr && host_wdata[0])) |=> !card_irq[0]);

  // R9
  host_set_chk: assert property (@(posedge clk) disable iff (rst)
    card_raise_host |=> host_irq);

  // R10
  host_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (bell_wr && host_wdata[CARD_IRQS] && !card_raise_host) |=> !host_irq);

  // R11
  bell_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!bell_wr && !card_raise_host && card_clr == '0) |=> $stable(bell_rdata));
endmodule

bind isa_window_doorbell isa_window_doorbell_chk #(
  .ADDR_W(ADDR_W), .REG_LSB(REG_LSB), .CARD_IRQS(CARD_IRQS)
) u_chk (.*);

// File: tb/tb_isa_window_doorbell.sv
module tb_isa_window_doorbell;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] host_addr = '0;
  logic        mem_strobe = 1'b0;
  logic        win_sel;
  logic        base_wr = 1'b0;
  logic        bell_wr = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  base_rdata;
  logic [2:0]  bell_rdata;
  logic        card_raise_host = 1'b0;
  logic [1:0]  card_clr = '0;
  logic        host_irq;
  logic [1:0]  card_irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // behavioural reference state
  int m_base = 'h80;
  int m_c0 = 0, m_c1 = 0, m_h = 0;

  always #2.5 clk = ~clk;

  isa_window_doorbell dut (
    .clk(clk), .rst(rst), .host_addr(host_addr), .mem_strobe(mem_strobe),
    .win_sel(win_sel), .base_wr(base_wr), .bell_wr(bell_wr),
    .host_wdata(host_wdata), .base_rdata(base_rdata), .bell_rdata(bell_rdata),
    .card_raise_host(card_raise_host), .card_clr(card_clr),
    .host_irq(host_irq), .card_irq(card_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_base = 'h80; m_c0 = 0; m_c1 = 0; m_h = 0;
    end else begin
      if (base_wr) m_base = 'h80 | (host_wdata & 'h7E);
      if (bell_wr && host_wdata[0]) m_c0 = 1;
      else if (card_clr[0]) m_c0 = 0;
      if (bell_wr && host_wdata[1]) m_c1 = 1;
      else if (card_clr[1]) m_c1 = 0;
      if (card_raise_host) m_h = 1;
      else if (bell_wr && host_wdata[2]) m_h = 0;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      int exp_sel;
      exp_sel = (mem_strobe && ((host_addr >> 13) == (m_base >> 1))) ? 1 : 0;
      chk(base_rdata[7] == 1'b1 && base_rdata[0] == 1'b0, "R2 fixed bits", base_rdata, m_base);
      chk(base_rdata == m_base[7:0], "R3 base readback", base_rdata, m_base);
      chk(win_sel == exp_sel[0], "R4 window select", win_sel, exp_sel);
      chk(bell_rdata[1:0] == {m_c1[0], m_c0[0]}, "R6 card flags", bell_rdata[1:0], m_c1*2 + m_c0);
      chk(bell_rdata[2] == m_h[0], "R10 host flag", bell_rdata[2], m_h);
      chk(host_irq == bell_rdata[2] && card_irq == bell_rdata[1:0], "R11 output levels",
          {host_irq, card_irq}, bell_rdata);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    base_wr = 0; bell_wr = 0; card_raise_host = 0; card_clr = '0; host_wdata = '0;
  endtask

  task automatic probe(input int addr, input bit strobe, input bit exp, input string req);
    host_addr = addr[19:0]; mem_strobe = strobe;
    #1;
    chk(win_sel == exp, req, win_sel, exp);
    mem_strobe = 0;
  endtask

  initial begin
    #1000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk); #1;
    // R1
    chk(base_rdata == 8'h80, "R1 reset base", base_rdata, 'h80);
    chk(bell_rdata == 3'b000 && host_irq == 0 && card_irq == 0, "R1 reset flags", bell_rdata, 0);
    probe('h80000, 1, 1, "R4 reset window low");
    probe('h81FFF, 1, 1, "R4 reset window top");
    probe('h82000, 1, 0, "R4 reset window above");
    probe('h7FFFF, 1, 0, "R4 below window");
    probe('h80000, 0, 0, "R5 no strobe");

    host_wdata = 8'h82; base_wr = 1; tick();
    chk(base_rdata == 8'h82, "R3 write 0x82", base_rdata, 'h82);
    probe('h82000, 1, 1, "R4 0x82000 base");
    probe('h83FFF, 1, 1, "R4 bit12 ignored");
    probe('h84000, 1, 0, "R4 past end");
    probe('h81FFF, 1, 0, "R4 before base");
    probe('h83000, 0, 0, "R5 strobe low in window");

    host_wdata = 8'hFF; base_wr = 1; tick();
    chk(base_rdata == 8'hFE, "R2 write all ones", base_rdata, 'hFE);
    probe('hFFFFF, 1, 1, "R4 top window");
    host_wdata = 8'h00; base_wr = 1; tick();
    chk(base_rdata == 8'h80, "R2 write zeros", base_rdata, 'h80);
    host_wdata = 8'h8A; base_wr = 1; tick();
    chk(base_rdata == 8'h8A, "R3 write 0x8A", base_rdata, 'h8A);
    probe('h8A800, 1, 1, "R4 0x8A window");

    host_wdata = 8'h01; bell_wr = 1; tick();
    chk(card_irq == 2'b01, "R6 set card0", card_irq, 1);
    host_wdata = 8'h00; bell_wr = 1; tick();
    chk(card_irq == 2'b01, "R6 zero write no effect", card_irq, 1);
    host_wdata = 8'h02; bell_wr = 1; tick();
    chk(card_irq == 2'b11, "R6 set card1", card_irq, 3);
    card_clr = 2'b01; tick();
    chk(card_irq == 2'b10, "R7 clear card0", card_irq, 2);
    host_wdata = 8'h02; bell_wr = 1; card_clr = 2'b10; tick();
    chk(card_irq == 2'b10, "R8 card set wins", card_irq, 2);
    card_clr = 2'b10; tick();
    chk(card_irq == 2'b00, "R7 clear card1", card_irq, 0);

    card_raise_host = 1; tick();
    chk(host_irq == 1 && bell_rdata[2] == 1, "R9 card raises host", host_irq, 1);
    host_wdata = 8'h03; bell_wr = 1; tick();
    chk(host_irq == 1, "R10 zero bit2 no effect", host_irq, 1);
    card_clr = 2'b11; tick();
    host_wdata = 8'h04; bell_wr = 1; card_raise_host = 1; tick();
    chk(host_irq == 1, "R8 host set wins", host_irq, 1);
    host_wdata = 8'h04; bell_wr = 1; tick();
    chk(host_irq == 0 && bell_rdata == 3'b000, "R10 host ack", bell_rdata, 0);

    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      host_addr       = {1'b1, 19'($urandom)};
      mem_strobe      = $urandom_range(0, 1);
      base_wr         = ($urandom_range(0, 7) == 0);
      bell_wr         = ($urandom_range(0, 3) == 0);
      host_wdata      = 8'($urandom);
      card_raise_host = ($urandom_range(0, 5) == 0);
      card_clr        = ($urandom_range(0, 2) == 0) ? 2'($urandom) : 2'b00;
    end
    tick();
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule